// File: doc/BRIEF.md
# Serial Two-Operand Adder/Subtractor

This block adds or subtracts two parallel operands of `W` bits (8 by default), one bit pair per clock. A `start` request loads both operands into right-shifting registers. A single full adder then combines the low bits with a stored carry, and each sum bit enters the top of a result register. After `W` shift cycles the result register holds the sum or difference modulo 2^W and `fin` goes high.

Subtraction uses the two's-complement identity A - B = A + ~B + 1. The carry is preset to 1 and every B bit is inverted on its way into the adder. A one-hot sequencer drives the two mode lines of the shift registers: `11` loads in parallel, `01` shifts right and `00` holds. The sequencer has four states: idle, load, shift and done. It leaves the done state only after `start` has been released, so each press of `start` runs exactly one operation.

Top module: `serial_addsub`

## Requirements
- R1: After the active-low asynchronous reset `rst_n`, the sequencer is in its idle state, `fin` is 0 and `result` is 0. Exactly one state bit is set at all times.
- R2: In idle with `start` low, the block stays in idle and `fin` stays 0. When `start` is high at a rising edge in idle, the load state follows on the next cycle.
- R3: In the load state both operands are captured in parallel. The result register is cleared. The carry is set to the value of `sub_sel`: 1 selects subtraction and presets the carry, 0 selects addition and clears it.
- R4: `fin` becomes 1 after exactly W+2 rising edges, counted from and including the first edge at which `start` is high in idle. At that point the shift counter holds W.
- R5: With `sub_sel` = 0 at load, `result` equals (A + B) mod 2^W when `fin` rises.
- R6: With `sub_sel` = 1 at load, `result` equals (A - B) mod 2^W when `fin` rises.
- R7: `sub_sel` is sampled only in the load state. Changing it during the shift cycles has no effect on the result.
- R8: While `start` stays high after completion, `fin` stays 1 and `result` stays unchanged. One edge after `start` goes low, `fin` returns to 0. `result` keeps its value until the next operation's load state.
- R9: Asserting `rst_n` low in the middle of an operation returns the block to idle, with `fin` at 0 and `result` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Operation request, level held until `fin` |
| sub_sel | input | 1 | 1 = subtract B from A, 0 = add |
| a_in | input | W | Operand A, parallel |
| b_in | input | W | Operand B, parallel |
| result | output | W | Parallel sum or difference |
| fin | output | 1 | High when the operation is complete |

## Verification
The in-line assertions check the following on every cycle:
- the sequencer stays one-hot;
- idle waits for `start`, and `start` in idle leads to load;
- the carry is initialised from `sub_sel` in load;
- the counter holds W whenever `fin` is high;
- the result is held while the done state is kept by `start`.

The arithmetic itself can only be shown by the bench's operand scenarios. These are additions and subtractions with carry or borrow out of the top bit, zero operands, a mid-shift toggle of `sub_sel`, the completion latency, and the release of `start`. Reset during an operation is also covered by a bench scenario.

// File: rtl/serial_addsub.sv
module serial_addsub #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         sub_sel,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] result,
  output logic         fin
);
  localparam int CW = $clog2(W + 1);
  localparam int IDLE = 0, LOAD = 1, SHIFT = 2, DONE = 3;

  logic [3:0]    st, nxt;
  logic [1:0]    mode;
  logic [W-1:0]  a_sr, b_sr, res;
  logic [CW-1:0] cnt;
  logic          cy, sub_q, last, bbit, sum, cout, clr;

  assign clr  = st[IDLE];
  assign last = st[SHIFT] && (cnt == CW'(W - 1));
  assign mode = st[LOAD] ? 2'b11 : (st[SHIFT] ? 2'b01 : 2'b00);
  assign bbit = b_sr[0] ^ sub_q;
  assign sum  = a_sr[0] ^ bbit ^ cy;
  assign cout = (a_sr[0] & bbit) | (a_sr[0] & cy) | (bbit & cy);
  assign fin    = st[DONE];
  assign result = res;

  always_comb begin
    nxt = '0;
    case (1'b1)
      st[IDLE]:  if (start) nxt[LOAD] = 1'b1; else nxt[IDLE] = 1'b1;
      st[LOAD]:  nxt[SHIFT] = 1'b1;
      st[SHIFT]: if (last) nxt[DONE] = 1'b1; else nxt[SHIFT] = 1'b1;
      st[DONE]:  if (start) nxt[DONE] = 1'b1; else nxt[IDLE] = 1'b1;
      default:   nxt[IDLE] = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= 4'b0001;
    else        st <= nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      a_sr <= '0;
      b_sr <= '0;
      res  <= '0;
    end else begin
      case (mode)
        2'b11: begin
          a_sr <= a_in;
          b_sr <= b_in;
          res  <= '0;
        end
        2'b01: begin
          a_sr <= a_sr >> 1;
          b_sr <= b_sr >> 1;
          res  <= {sum, res[W-1:1]};
        end
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cy    <= 1'b0;
      sub_q <= 1'b0;
      cnt   <= '0;
    end else begin
      if (clr)            cy <= 1'b0;
      else if (st[LOAD])  cy <= sub_sel;
      else if (st[SHIFT]) cy <= cout;
      if (st[LOAD]) sub_q <= sub_sel;
      if (clr)            cnt <= '0;
      else if (st[SHIFT]) cnt <= cnt + 1'b1;
    end

  AST_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n) $countones(st) == 1); // R1
  AST_IDLE_WAIT: assert property (@(posedge clk) disable iff (!rst_n) (st[IDLE] && !start) |=> (st[IDLE] && !fin)); // R2
  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (st[IDLE] && start) |=> st[LOAD]); // R2
  AST_CARRY_INIT: assert property (@(posedge clk) disable iff (!rst_n) st[LOAD] |=> (cy == $past(sub_sel))); // R3
  AST_FIN_COUNT: assert property (@(posedge clk) disable iff (!rst_n) fin |-> (cnt == CW'(W))); // R4
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (fin && start) |=> (fin && $stable(res))); // R8
  AST_FIN_DROP: assert property (@(posedge clk) disable iff (!rst_n) (fin && !start) |=> !fin); // R8
endmodule

// File: tb/tb_serial_addsub.sv
module tb_serial_addsub;
  localparam int W = 8;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, sub_sel = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] result;
  logic fin;
  int n_cmp = 0, n_bad = 0;
  logic [W-1:0] exp_q[$];
  string tag_q[$];

  serial_addsub #(.W(W)) dut (.clk(clk), .rst_n(rst_n), .start(start), .sub_sel(sub_sel),
    .a_in(a_in), .b_in(b_in), .result(result), .fin(fin));

  always #4 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  // monitor: compares each completion against the scoreboard
  initial begin
    forever begin
      @(posedge fin);
      @(negedge clk);
      if (exp_q.size() == 0) check("R5 unexpected result", 1, 0);
      else check(tag_q.pop_front(), int'(result), int'(exp_q.pop_front()));
    end
  end

  // driver: one operation; toggles sub_sel mid-shift when asked
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic sub,
                        input logic toggle, input int hold);
    int edges;
    logic [W-1:0] e;
    e = sub ? W'(a - b) : W'(a + b);
    exp_q.push_back(e);
    tag_q.push_back(toggle ? "R7 mode held" : (sub ? "R6 difference" : "R5 sum"));
    @(negedge clk);
    a_in = a; b_in = b; sub_sel = sub; start = 1'b1;
    edges = 0;
    while (!fin && edges < 40) begin
      @(posedge clk); edges++;
      if (toggle && edges == 4) begin @(negedge clk); sub_sel = ~sub; end
      else #1;
    end
    @(negedge clk);
    check("R4 latency", edges, W + 2);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      a_in = ~a_in;
      check("R8 fin held", int'(fin), 1);
      check("R8 result held", int'(result), int'(e));
    end
    start = 1'b0;
    @(negedge clk);
    check("R8 fin drop", int'(fin), 0);
    @(negedge clk);
    check("R8 result kept", int'(result), int'(e));
  endtask

  initial begin
    #20;
    check("R1 reset fin", int'(fin), 0);
    check("R1 reset result", int'(result), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R2 idle no fin", int'(fin), 0);
    run_op(8'd23, 8'd45, 1'b0, 1'b0, 0);
    run_op(8'd255, 8'd1, 1'b0, 1'b0, 2);
    run_op(8'd200, 8'd100, 1'b0, 1'b0, 0);
    run_op(8'd0, 8'd0, 1'b0, 1'b0, 0);        // R3 cleared carry on add
    run_op(8'd100, 8'd37, 1'b1, 1'b0, 0);
    run_op(8'd0, 8'd1, 1'b1, 1'b0, 0);
    run_op(8'd128, 8'd1, 1'b1, 1'b0, 3);
    run_op(8'd77, 8'd0, 1'b1, 1'b0, 0);       // R3 preset carry on subtract
    run_op(8'd10, 8'd20, 1'b1, 1'b1, 0);
    run_op(8'd10, 8'd20, 1'b0, 1'b1, 0);
    // R9 reset mid-operation
    @(negedge clk);
    a_in = 8'd9; b_in = 8'd3; sub_sel = 1'b0; start = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R9 reset fin", int'(fin), 0);
    check("R9 reset result", int'(result), 0);
    start = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (W + 4) @(negedge clk);
    check("R9 stays idle", int'(fin), 0);
    run_op(8'd60, 8'd70, 1'b1, 1'b0, 0);
    repeat (3) @(negedge clk);
    check("R5 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule